// File: doc/BRIEF.md
# Tagged FIFO Link Port

A one-way, point-to-point channel that joins a processor's register file to a piece of custom logic through a small FIFO. Each entry holds a 32-bit word and one tag bit. Software can use the tag bit to mark a word as control rather than data. On the processor side the block accepts a single request line together with two qualifiers. One qualifier picks waiting (blocking) or trying once (non-blocking). The other picks a data or a control put. The block returns a stall line, a registered success flag that the pipeline can copy into its carry bit, and the word and tag taken by the last successful get.

A parameter fixes the direction of one instance. With `TO_HW = 1` the processor puts words and the logic drains them through a valid/ready stream. With `TO_HW = 0` the logic fills the FIFO through a valid/ready stream and the processor gets the words. A two-way link uses two instances, one of each kind. Each FIFO has exactly one writer and one reader, there is no arbitration, and everything runs on one clock.

Top module: `fifo_link_port`

## Requirements
- R1: Words leave the FIFO in the order they entered. Each word keeps its own tag bit: the stream output carries the tag on `hw_out_tag` and the word on `hw_out_data`.
- R2: A put with `cpu_ctl = 0` stores tag 0. A put with `cpu_ctl = 1` stores tag 1.
- R3: A blocking get (`cpu_req = 1`, `cpu_nb = 0`) on an empty FIFO raises `cpu_stall` in the same cycle and takes nothing. The stall lasts until a word is present.
- R4: A blocking put on a full FIFO raises `cpu_stall` in the same cycle and stores nothing.
- R5: A non-blocking request never raises `cpu_stall`. One cycle after any request cycle, `cpu_ok` is 1 if the word moved and 0 if it did not. `cpu_ok` is 0 after a cycle with no request.
- R6: A failed non-blocking get leaves `cpu_rdata` and `cpu_rctl` unchanged and removes no word. A failed non-blocking put adds no word.
- R7: One cycle after a successful get, `cpu_rdata` holds the word taken and `cpu_rctl` holds its tag.
- R8: The FIFO holds exactly `DEPTH` entries (default 16). `hw_in_ready` is low only when it is full. `hw_out_valid` is high exactly when it is not empty.
- R9: A push and a pop in the same cycle are both performed and leave the fill level unchanged, so one word per cycle can stream through.
- R10: A synchronous reset (`rst` high) empties the FIFO and holds `cpu_stall` and `cpu_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request (put if TO_HW=1, get if TO_HW=0) |
| cpu_nb | input | 1 | 1 = non-blocking attempt |
| cpu_ctl | input | 1 | Tag value for a put (1 = control word) |
| cpu_wdata | input | 32 | Word for a put |
| cpu_rdata | output | 32 | Word taken by the last successful get |
| cpu_rctl | output | 1 | Tag of the last successful get |
| cpu_stall | output | 1 | Blocking request cannot complete this cycle |
| cpu_ok | output | 1 | Previous cycle's request moved a word |
| hw_in_valid | input | 1 | Stream input word valid (TO_HW=0) |
| hw_in_tag | input | 1 | Stream input tag |
| hw_in_data | input | 32 | Stream input word |
| hw_in_ready | output | 1 | FIFO can accept a stream word |
| hw_out_valid | output | 1 | Stream output word valid (TO_HW=1) |
| hw_out_tag | output | 1 | Stream output tag |
| hw_out_data | output | 32 | Stream output word |
| hw_out_ready | input | 1 | Consumer takes the stream word |

## Verification
Both directions are run with directed sequences. These cover a FIFO that starts empty and is filled to exactly its depth, a non-blocking and a blocking attempt against each limit, and a push and a pop in the same cycle at a steady fill level. The directed sequences separate a wrong full/empty decision from a wrong fill count. Seeded random mixes then vary requests, the blocking choice, tags and the handshake lines together. A queue model kept in the bench predicts the stall, the success flag, the stream head and the returned word in every cycle, so lost, duplicated, reordered or mis-tagged words stand out. Resets in the middle of traffic check that everything is dropped.

// File: rtl/slink_pkg.sv
package slink_pkg;

    parameter int unsigned WORD_W = 32;

    typedef struct packed {
        logic              tag;
        logic [WORD_W-1:0] word;
    } link_entry_t;

    typedef struct packed {
        logic              ok;
        logic              rtag;
        logic [WORD_W-1:0] rword;
    } port_reg_t;

endpackage

// File: rtl/slink_fifo.sv
module slink_fifo
    import slink_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  link_entry_t push_entry,
    input  logic        pop,
    output link_entry_t head,
    output logic        full,
    output logic        empty
);
    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t        st_d, st_q;
    link_entry_t mem_q [DEPTH];
    logic [AW:0] level;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = st_q.wp + 1'b1;
            if (pop)  st_d.rp = st_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp[AW-1:0]] <= push_entry;
    end

    assign empty = (st_q.wp == st_q.rp);
    assign full  = (st_q.wp[AW] != st_q.rp[AW]) &&
                   (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
    assign head  = mem_q[st_q.rp[AW-1:0]];
    assign level = st_q.wp - st_q.rp;

    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    a_r9_level_held: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (level == $past(level)));

endmodule

// File: rtl/slink_cpu_port.sv
module slink_cpu_port
    import slink_pkg::*;
#(
    parameter bit IS_PUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              nb,
    input  logic              ctl,
    input  logic [WORD_W-1:0] wdata,
    input  logic              full,
    input  logic              empty,
    input  link_entry_t       head,
    output logic              push,
    output link_entry_t       push_entry,
    output logic              pop,
    output logic              stall,
    output logic              ok,
    output logic [WORD_W-1:0] rdata,
    output logic              rctl
);
    port_reg_t r_d, r_q;
    logic      room;
    logic      go;

    always_comb begin
        room  = IS_PUT ? !full : !empty;
        go    = req && room && !rst;
        stall = req && !nb && !room && !rst;
        push  = IS_PUT && go;
        pop   = !IS_PUT && go;
        push_entry.tag  = ctl;
        push_entry.word = wdata;

        r_d    = r_q;
        r_d.ok = go;
        if (pop) begin
            r_d.rword = head.word;
            r_d.rtag  = head.tag;
        end
        if (rst) r_d = '0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign ok    = r_q.ok;
    assign rdata = r_q.rword;
    assign rctl  = r_q.rtag;

    a_r6_rdata_held: assert property (@(posedge clk) disable iff (rst)
        !$past(pop) |-> ($stable(rdata) && $stable(rctl)));
    a_r5_ok_needs_request: assert property (@(posedge clk) disable iff (rst)
        ok |-> $past(req));

endmodule

// File: rtl/fifo_link_port.sv
module fifo_link_port
    import slink_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter bit          TO_HW = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_nb,
    input  logic              cpu_ctl,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_rctl,
    output logic              cpu_stall,
    output logic              cpu_ok,
    input  logic              hw_in_valid,
    input  logic              hw_in_tag,
    input  logic [WORD_W-1:0] hw_in_data,
    output logic              hw_in_ready,
    output logic              hw_out_valid,
    output logic              hw_out_tag,
    output logic [WORD_W-1:0] hw_out_data,
    input  logic              hw_out_ready
);
    link_entry_t port_entry, hw_entry, fifo_entry, head;
    logic        port_push, port_pop, hw_push, hw_pop;
    logic        fifo_push, fifo_pop, full, empty;

    slink_cpu_port #(.IS_PUT(TO_HW)) port_i (
        .clk        (clk),
        .rst        (rst),
        .req        (cpu_req),
        .nb         (cpu_nb),
        .ctl        (cpu_ctl),
        .wdata      (cpu_wdata),
        .full       (full),
        .empty      (empty),
        .head       (head),
        .push       (port_push),
        .push_entry (port_entry),
        .pop        (port_pop),
        .stall      (cpu_stall),
        .ok         (cpu_ok),
        .rdata      (cpu_rdata),
        .rctl       (cpu_rctl)
    );

    assign hw_entry.tag  = hw_in_tag;
    assign hw_entry.word = hw_in_data;
    assign hw_push = !TO_HW && hw_in_valid && !full && !rst;
    assign hw_pop  = TO_HW && hw_out_ready && !empty && !rst;

    assign fifo_push  = TO_HW ? port_push : hw_push;
    assign fifo_pop   = TO_HW ? hw_pop : port_pop;
    assign fifo_entry = TO_HW ? port_entry : hw_entry;

    slink_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .push       (fifo_push),
        .push_entry (fifo_entry),
        .pop        (fifo_pop),
        .head       (head),
        .full       (full),
        .empty      (empty)
    );

    assign hw_in_ready  = !TO_HW && !full;
    assign hw_out_valid = TO_HW && !empty;
    assign hw_out_tag   = head.tag;
    assign hw_out_data  = head.word;

    generate
        if (TO_HW) begin : g_chk_tx
            a_r4_stall_only_full: assert property (@(posedge clk) disable iff (rst)
                cpu_stall |-> hw_out_valid);
            a_r1_valid_persists: assert property (@(posedge clk) disable iff (rst)
                (hw_out_valid && !hw_out_ready) |=> hw_out_valid);
        end else begin : g_chk_rx
            a_r3_stall_only_empty: assert property (@(posedge clk) disable iff (rst)
                cpu_stall |-> hw_in_ready);
            a_r8_ready_persists: assert property (@(posedge clk) disable iff (rst)
                (!hw_in_ready && !cpu_req) |=> !hw_in_ready);
        end
    endgenerate

endmodule

// File: tb/fifo_link_port_tb_top.sv
module fifo_link_port_tb_top;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // TX instance: processor puts, stream drains
    logic        t_req = 0, t_nb = 0, t_ctl = 0, t_rdy = 0;
    logic [31:0] t_wdata = 0;
    logic [31:0] t_rdata, t_odata, t_idata_unused;
    logic        t_rctl, t_stall, t_ok, t_iready, t_ovalid, t_otag;
    // RX instance: stream fills, processor gets
    logic        r_req = 0, r_nb = 0, r_vld = 0, r_tag = 0;
    logic [31:0] r_idata = 0;
    logic [31:0] r_rdata, r_odata;
    logic        r_rctl, r_stall, r_ok, r_iready, r_ovalid, r_otag;

    assign t_idata_unused = 32'h0;

    fifo_link_port #(.DEPTH(DEPTH), .TO_HW(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(t_req), .cpu_nb(t_nb), .cpu_ctl(t_ctl),
        .cpu_wdata(t_wdata), .cpu_rdata(t_rdata), .cpu_rctl(t_rctl),
        .cpu_stall(t_stall), .cpu_ok(t_ok), .hw_in_valid(1'b0), .hw_in_tag(1'b0),
        .hw_in_data(t_idata_unused), .hw_in_ready(t_iready), .hw_out_valid(t_ovalid),
        .hw_out_tag(t_otag), .hw_out_data(t_odata), .hw_out_ready(t_rdy));

    fifo_link_port #(.DEPTH(DEPTH), .TO_HW(1'b0)) dut_rx_i (
        .clk(clk), .rst(rst), .cpu_req(r_req), .cpu_nb(r_nb), .cpu_ctl(1'b0),
        .cpu_wdata(32'h0), .cpu_rdata(r_rdata), .cpu_rctl(r_rctl),
        .cpu_stall(r_stall), .cpu_ok(r_ok), .hw_in_valid(r_vld), .hw_in_tag(r_tag),
        .hw_in_data(r_idata), .hw_in_ready(r_iready), .hw_out_valid(r_ovalid),
        .hw_out_tag(r_otag), .hw_out_data(r_odata), .hw_out_ready(1'b0));

    int unsigned total = 0;
    int unsigned fails = 0;
    logic [32:0] tq[$];
    logic [32:0] rq[$];
    logic [32:0] r_last = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic would_stall(input logic req, input logic nb, input logic room);
        return req && !nb && !room;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        t_req = 0; r_req = 1; r_nb = 0; r_vld = 0; t_rdy = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R10 rx stall in reset", r_stall, 0);
        chk("R10 rx ok in reset", r_ok, 0);
        chk("R10 tx empty after reset", t_ovalid, 0);
        chk("R10 rx ready after reset", r_iready, 1);
        chk("R10 tx ok in reset", t_ok, 0);
        @(negedge clk);
        rst = 1'b0; r_req = 0;
        tq.delete(); rq.delete(); r_last = '0;
    endtask

    task automatic tx_cycle(input logic req, input logic nb, input logic ctl,
                            input logic [31:0] d, input logic rdy);
        logic room, pushes, pops;
        @(negedge clk);
        t_req = req; t_nb = nb; t_ctl = ctl; t_wdata = d; t_rdy = rdy;
        #1;
        room = tq.size() < DEPTH;
        chk("R4/R5 tx stall", t_stall, would_stall(req, nb, room));
        chk("R8 tx out valid", t_ovalid, tq.size() > 0);
        if (tq.size() > 0) begin
            chk("R1 tx head word", t_odata, tq[0][31:0]);
            chk("R2 tx head tag", t_otag, tq[0][32]);
        end
        pushes = req && room;
        pops = rdy && (tq.size() > 0);
        @(posedge clk); #1;
        if (pops) void'(tq.pop_front());
        if (pushes) tq.push_back({ctl, d});
        chk("R5 tx ok", t_ok, pushes);
    endtask

    task automatic rx_cycle(input logic req, input logic nb, input logic vld,
                            input logic tg, input logic [31:0] d);
        logic room, gets, puts;
        @(negedge clk);
        r_req = req; r_nb = nb; r_vld = vld; r_tag = tg; r_idata = d;
        #1;
        room = rq.size() > 0;
        chk("R3/R5 rx stall", r_stall, would_stall(req, nb, room));
        chk("R8 rx in ready", r_iready, rq.size() < DEPTH);
        gets = req && room;
        puts = vld && (rq.size() < DEPTH);
        @(posedge clk); #1;
        if (gets) r_last = rq.pop_front();
        if (puts) rq.push_back({tg, d});
        chk("R5 rx ok", r_ok, gets);
        chk("R6/R7 rx word", r_rdata, r_last[31:0]);
        chk("R7 rx tag", r_rctl, r_last[32]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R1 R2: mixed tags, in-order drain
        tx_cycle(1, 0, 0, 32'hA5A5_0001, 0);
        tx_cycle(1, 0, 1, 32'h5A5A_0002, 0);
        tx_cycle(1, 1, 0, 32'hFFFF_0003, 0);
        repeat (4) tx_cycle(0, 0, 0, 0, 1);

        // R8 R4 R6: fill to depth, overfill attempts, drain
        for (int i = 0; i < DEPTH; i++) tx_cycle(1, 1, i[0], 32'h100 + i, 0);
        chk("R8 tx exactly full", tq.size(), DEPTH);
        tx_cycle(1, 1, 1, 32'hDEAD_BEEF, 0);
        tx_cycle(1, 0, 0, 32'hDEAD_BEEF, 0);
        tx_cycle(1, 0, 0, 32'hDEAD_BEEF, 0);
        for (int i = 0; i < DEPTH + 1; i++) tx_cycle(0, 0, 0, 0, 1);
        chk("R6 tx nothing left", t_ovalid, 0);

        // R9: streaming with simultaneous push and pop at level 5
        for (int i = 0; i < 5; i++) tx_cycle(1, 0, 0, 32'h200 + i, 0);
        for (int i = 0; i < 30; i++) tx_cycle(1, 0, i[1], 32'h300 + i, 1);
        chk("R9 tx level unchanged", tq.size(), 5);
        // full with pop: push refused this cycle
        for (int i = 0; i < 11; i++) tx_cycle(1, 1, 0, 32'h400 + i, 0);
        tx_cycle(1, 1, 0, 32'h4FF, 1);
        tx_cycle(1, 1, 0, 32'h500, 1);

        // R10: reset drops queued words
        do_reset();

        // R3 R6 R7: rx side
        rx_cycle(1, 0, 0, 0, 0);
        rx_cycle(1, 0, 0, 0, 0);
        rx_cycle(1, 1, 0, 0, 0);
        rx_cycle(0, 0, 1, 1, 32'hC0DE_0001);
        rx_cycle(1, 1, 1, 0, 32'hC0DE_0002);
        rx_cycle(1, 0, 0, 0, 0);
        rx_cycle(1, 1, 0, 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) rx_cycle(0, 0, 1, i[0], 32'h600 + i);
        chk("R8 rx exactly full", rq.size(), DEPTH);
        for (int i = 0; i < DEPTH; i++) rx_cycle(1, 0, 1, 1, 32'h700 + i);
        for (int i = 0; i < DEPTH + 1; i++) rx_cycle(1, 1, 0, 0, 0);

        // random mixes
        for (int i = 0; i < 600; i++)
            tx_cycle($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom, ($urandom_range(0, 3) != 0));
        for (int i = 0; i < 600; i++)
            rx_cycle($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) != 0),
                     $urandom_range(0, 1), $urandom);
        do_reset();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule